// File: doc/BRIEF.md
# Wide Byte-Lane Data Shuffler

This block is a single-cycle data-preparation stage placed between a wide memory read port and a SIMD compute array. Every clock it can accept one operation that reads one or two full rows of bytes (256 bytes by default, handled as 64-byte groups), reshapes them, and stores the outcome in one of four row-wide internal registers. The same value is presented on a registered result port for the following stage.

Operands come from eight sources: the two memory-read rows, the four internal registers, a row forwarded back from a later stage, and a constant all-zero row. The reshaping operations are copy, whole-row rotate, per-group byte broadcast, masked merge, per-group edge swap and pairwise signed-max compression. A per-byte merge mask is held in an internal mask register that a dedicated operation loads from a source row.

Top module: `wide_row_shuffler`

## Requirements
- R1: After reset `res_valid` is 0, `res_row` is all zero, and all four registers and the mask register hold zero.
- R2: Source select codes are 0 = memory row A, 1 = memory row B, 2..5 = register 0..3, 6 = forwarded row, 7 = all-zero row. Operation code 0 (copy) writes source A unchanged to the destination register.
- R3: Operation code 1 (rotate) uses `op_imm[2:0]`: code c in 0..6 gives output byte i = input byte (i - 2^c) mod N; code 7 gives output byte i = input byte (i + 1) mod N. Byte i occupies bits 8i+7..8i.
- R4: Operation code 2 (broadcast) copies byte `op_imm` of each 64-byte group of source A into all 64 bytes of that group.
- R5: Operation code 3 (merge) produces byte i from source A when mask bit i is 1 and from source B when it is 0.
- R6: Operation code 4 (edge swap) exchanges byte 0 and byte 63 of every 64-byte group of source A; other bytes pass unchanged.
- R7: Operation code 5 (compress) writes into byte j (j < N/2) the signed maximum of source A bytes 2j and 2j+1, and zero into the upper half of the row.
- R8: Operation code 6 (mask load) loads mask bit i from bit i of source A (i < N); it writes no register and leaves `res_valid` low.
- R9: Each register-writing operation completes in one clock: `res_valid`, `res_dst` and `res_row` reflect it after the issuing edge, and an operation on the next cycle reads the newly written register.
- R10: Operation code 7 writes nothing, leaves `res_valid` low and leaves all registers unchanged.
- R11: With `op_valid` low no register or mask changes and `res_valid` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 3 | Operation select |
| op_src_a | input | 3 | Source A select |
| op_src_b | input | 3 | Source B select (merge) |
| op_dst | input | 2 | Destination register |
| op_imm | input | IMM_W | Broadcast byte index; low 3 bits pick rotate amount |
| mem_row_a | input | ROW_BYTES*8 | First memory read row |
| mem_row_b | input | ROW_BYTES*8 | Second memory read row |
| fwd_row | input | ROW_BYTES*8 | Row forwarded from a later stage |
| res_valid | output | 1 | A register was written at the last edge |
| res_dst | output | 2 | Register written at the last edge |
| res_row | output | ROW_BYTES*8 | Value written at the last edge |

## Verification
Every result of this block is due exactly one clock after its issuing edge: the register write, `res_valid`, `res_dst` and `res_row` all update at that edge, and a dependent operation in the very next cycle already sees the new register value. The driver applies one operation per falling edge and queues the outcome it expects from a bench-side model of the registers and mask; the monitor pops one entry a nanosecond after each following rising edge, so each comparison lands in the single cycle the result is due. Operations that must not write (mask load, code 7, idle cycles) queue an entry expecting `res_valid` low, and a later copy from the untouched register shows its contents survived.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

   typedef enum logic [2:0] {
      OP_COPY  = 3'd0,
      OP_ROT   = 3'd1,
      OP_BCAST = 3'd2,
      OP_MERGE = 3'd3,
      OP_ESWAP = 3'd4,
      OP_CMPR  = 3'd5,
      OP_MASK  = 3'd6,
      OP_NOP   = 3'd7
   } shuf_op_e;

   localparam logic [2:0] SRC_MEM_A = 3'd0;
   localparam logic [2:0] SRC_MEM_B = 3'd1;
   localparam logic [2:0] SRC_REG0  = 3'd2;
   localparam logic [2:0] SRC_FWD   = 3'd6;
   localparam logic [2:0] SRC_ZERO  = 3'd7;

   function automatic logic op_writes(input shuf_op_e op);
      return (op != OP_MASK) && (op != OP_NOP);
   endfunction

endpackage

// File: rtl/shuf_src_mux.sv
module shuf_src_mux #(
   parameter int ROW_W = 2048,
   parameter int NREGS = 4
) (
   input  logic [2:0]                  sel_i,
   input  logic [ROW_W-1:0]            mem_a_i,
   input  logic [ROW_W-1:0]            mem_b_i,
   input  logic [ROW_W-1:0]            fwd_i,
   input  logic [NREGS-1:0][ROW_W-1:0] regs_i,
   output logic [ROW_W-1:0]            row_o
);
   import shuf_pkg::*;

   logic [7:0][ROW_W-1:0] cand;

   assign cand[SRC_MEM_A] = mem_a_i;
   assign cand[SRC_MEM_B] = mem_b_i;
   assign cand[SRC_FWD]   = fwd_i;
   assign cand[SRC_ZERO]  = '0;

   for (genvar r = 0; r < NREGS; r++) begin : g_reg_src
      assign cand[int'(SRC_REG0) + r] = regs_i[r];
   end

   assign row_o = cand[sel_i];

endmodule

// File: rtl/shuf_rotate.sv
module shuf_rotate #(
   parameter int ROW_BYTES = 256
) (
   input  logic [ROW_BYTES*8-1:0] row_i,
   input  logic [2:0]             amt_i,
   output logic [ROW_BYTES*8-1:0] row_o
);
   localparam int ROW_W   = ROW_BYTES * 8;
   localparam int N_POW2  = 7;

   if (ROW_BYTES <= 64) begin : g_bad_len
      $error("shuf_rotate: ROW_BYTES must exceed the largest rotate step of 64");
   end

   logic [N_POW2:0][ROW_W-1:0] cand;

   for (genvar k = 0; k < N_POW2; k++) begin : g_step
      localparam int SH = 8 * (1 << k);
      assign cand[k] = (row_i << SH) | (row_i >> (ROW_W - SH));
   end

   // code 7: one byte toward the low end
   assign cand[N_POW2] = (row_i >> 8) | (row_i << (ROW_W - 8));

   assign row_o = cand[amt_i];

endmodule

// File: rtl/shuf_group_ops.sv
module shuf_group_ops #(
   parameter int ROW_BYTES = 256,
   parameter int GRP_BYTES = 64,
   parameter int IMM_W     = 6
) (
   input  logic [ROW_BYTES*8-1:0] row_i,
   input  logic [IMM_W-1:0]       idx_i,
   output logic [ROW_BYTES*8-1:0] bcast_o,
   output logic [ROW_BYTES*8-1:0] eswap_o,
   output logic [ROW_BYTES*8-1:0] cmpr_o
);
   localparam int ROW_W  = ROW_BYTES * 8;
   localparam int GRP_W  = GRP_BYTES * 8;
   localparam int N_GRP  = ROW_BYTES / GRP_BYTES;
   localparam int N_PAIR = ROW_BYTES / 2;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic [GRP_BYTES-1:0][7:0] grp;
      logic [7:0]                pick;
      assign grp  = row_i[g*GRP_W +: GRP_W];
      assign pick = grp[idx_i];
      assign bcast_o[g*GRP_W +: GRP_W] = {GRP_BYTES{pick}};

      for (genvar b = 0; b < GRP_BYTES; b++) begin : g_byte
         if (b == 0) begin : g_first
            assign eswap_o[g*GRP_W + b*8 +: 8] = grp[GRP_BYTES-1];
         end else if (b == GRP_BYTES - 1) begin : g_last
            assign eswap_o[g*GRP_W + b*8 +: 8] = grp[0];
         end else begin : g_mid
            assign eswap_o[g*GRP_W + b*8 +: 8] = grp[b];
         end
      end
   end

   for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
      logic [7:0] lo_b, hi_b;
      assign lo_b = row_i[(2*j)*8 +: 8];
      assign hi_b = row_i[(2*j+1)*8 +: 8];
      assign cmpr_o[j*8 +: 8] = ($signed(lo_b) >= $signed(hi_b)) ? lo_b : hi_b;
   end
   assign cmpr_o[ROW_W-1:ROW_W/2] = '0;

endmodule

// File: rtl/wide_row_shuffler.sv
module wide_row_shuffler #(
   parameter int ROW_BYTES = 256,
   parameter int GRP_BYTES = 64,
   parameter int IMM_W     = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [2:0]             op_code,
   input  logic [2:0]             op_src_a,
   input  logic [2:0]             op_src_b,
   input  logic [1:0]             op_dst,
   input  logic [IMM_W-1:0]       op_imm,
   input  logic [ROW_BYTES*8-1:0] mem_row_a,
   input  logic [ROW_BYTES*8-1:0] mem_row_b,
   input  logic [ROW_BYTES*8-1:0] fwd_row,
   output logic                   res_valid,
   output logic [1:0]             res_dst,
   output logic [ROW_BYTES*8-1:0] res_row
);
   import shuf_pkg::*;

   localparam int ROW_W = ROW_BYTES * 8;
   localparam int NREGS = 4;
   localparam int GRP_W = GRP_BYTES * 8;

   if (ROW_BYTES % GRP_BYTES != 0) begin : g_bad_grp
      $error("wide_row_shuffler: ROW_BYTES must be a multiple of GRP_BYTES");
   end
   if ((1 << IMM_W) != GRP_BYTES) begin : g_bad_imm
      $error("wide_row_shuffler: IMM_W must index exactly one group");
   end
   if (GRP_BYTES < 2) begin : g_bad_small
      $error("wide_row_shuffler: a group needs at least two bytes");
   end

   logic [NREGS-1:0][ROW_W-1:0] regs_q;
   logic [ROW_BYTES-1:0]        mask_q;
   logic [ROW_W-1:0]            row_a, row_b;
   logic [ROW_W-1:0]            rot_row, bcast_row, eswap_row, cmpr_row, merge_row;
   logic [ROW_W-1:0]            result;
   shuf_op_e                    op;
   logic                        wr_en;

   assign op    = shuf_op_e'(op_code);
   assign wr_en = op_valid && op_writes(op);

   shuf_src_mux #(.ROW_W(ROW_W), .NREGS(NREGS)) i_mux_a (
      .sel_i(op_src_a), .mem_a_i(mem_row_a), .mem_b_i(mem_row_b),
      .fwd_i(fwd_row), .regs_i(regs_q), .row_o(row_a));

   shuf_src_mux #(.ROW_W(ROW_W), .NREGS(NREGS)) i_mux_b (
      .sel_i(op_src_b), .mem_a_i(mem_row_a), .mem_b_i(mem_row_b),
      .fwd_i(fwd_row), .regs_i(regs_q), .row_o(row_b));

   shuf_rotate #(.ROW_BYTES(ROW_BYTES)) i_rot (
      .row_i(row_a), .amt_i(op_imm[2:0]), .row_o(rot_row));

   shuf_group_ops #(.ROW_BYTES(ROW_BYTES), .GRP_BYTES(GRP_BYTES), .IMM_W(IMM_W)) i_grp (
      .row_i(row_a), .idx_i(op_imm), .bcast_o(bcast_row),
      .eswap_o(eswap_row), .cmpr_o(cmpr_row));

   for (genvar i = 0; i < ROW_BYTES; i++) begin : g_merge
      assign merge_row[i*8 +: 8] = mask_q[i] ? row_a[i*8 +: 8] : row_b[i*8 +: 8];
   end

   always_comb begin
      case (op)
         OP_ROT:   result = rot_row;
         OP_BCAST: result = bcast_row;
         OP_MERGE: result = merge_row;
         OP_ESWAP: result = eswap_row;
         OP_CMPR:  result = cmpr_row;
         default:  result = row_a;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q    <= '0;
         mask_q    <= '0;
         res_valid <= 1'b0;
         res_dst   <= '0;
         res_row   <= '0;
      end else begin
         res_valid <= wr_en;
         if (wr_en) begin
            regs_q[op_dst] <= result;
            res_dst        <= op_dst;
            res_row        <= result;
         end
         if (op_valid && op == OP_MASK) begin
            mask_q <= row_a[ROW_BYTES-1:0];
         end
      end
   end

   // R9: a writing operation shows up on the result port one edge later
   a_r9_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (res_valid && res_dst == $past(op_dst)));

   // R11: idle cycles leave no result
   a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);

   // R8: mask load writes no register
   a_r8_maskld_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_MASK) |=> !res_valid);

   // R10: code 7 writes nothing
   a_r10_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_NOP) |=> !res_valid);

   // R7: compress leaves the upper half zero
   a_r7_compress_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_CMPR) |=> (res_row[ROW_W-1:ROW_W/2] == '0));

   // R4: broadcast makes the first and last byte of group 0 equal
   a_r4_bcast_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_BCAST) |=> (res_row[7:0] == res_row[GRP_W-8 +: 8]));

endmodule

// File: tb/test_wide_row_shuffler.sv
`timescale 1ns/1ps
module test_wide_row_shuffler;
   localparam int RB = 256;
   localparam int W  = RB * 8;
   localparam int GB = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op_code = '0, op_src_a = '0, op_src_b = '0;
   logic [1:0]    op_dst = '0;
   logic [5:0]    op_imm = '0;
   logic [W-1:0]  mem_row_a, mem_row_b, fwd_row;
   logic          res_valid;
   logic [1:0]    res_dst;
   logic [W-1:0]  res_row;

   always #2.5 clk = ~clk;

   wide_row_shuffler i_wide_row_shuffler (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst), .op_imm(op_imm),
      .mem_row_a(mem_row_a), .mem_row_b(mem_row_b), .fwd_row(fwd_row),
      .res_valid(res_valid), .res_dst(res_dst), .res_row(res_row));

   typedef struct packed {
      logic         v;
      logic [1:0]   d;
      logic [W-1:0] row;
   } exp_t;

   exp_t         exp_q[$];
   string        tag_q[$];
   int           checks = 0;
   int           errors = 0;
   logic [W-1:0] m_regs [4];
   logic [RB-1:0] m_mask;

   function automatic logic [7:0] byt(input logic [W-1:0] r, input int i);
      return r[i*8 +: 8];
   endfunction

   function automatic logic [W-1:0] m_src(input logic [2:0] s);
      case (s)
         3'd0: return mem_row_a;
         3'd1: return mem_row_b;
         3'd6: return fwd_row;
         3'd7: return '0;
         default: return m_regs[s - 3'd2];
      endcase
   endfunction

   function automatic logic [W-1:0] m_rot(input logic [W-1:0] r, input logic [2:0] c);
      logic [W-1:0] o;
      int k = (c == 3'd7) ? -1 : (1 << c);
      for (int i = 0; i < RB; i++) o[i*8 +: 8] = byt(r, (i - k + RB) % RB);
      return o;
   endfunction

   function automatic logic [W-1:0] m_model(input logic [2:0] op, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [5:0] imm);
      logic [W-1:0] o;
      o = a;
      case (op)
         3'd1: o = m_rot(a, imm[2:0]);
         3'd2: for (int i = 0; i < RB; i++) o[i*8 +: 8] = byt(a, (i / GB) * GB + imm);
         3'd3: for (int i = 0; i < RB; i++) o[i*8 +: 8] = m_mask[i] ? byt(a, i) : byt(b, i);
         3'd4: for (int g = 0; g < RB / GB; g++) begin
                  o[(g*GB)*8 +: 8]        = byt(a, g*GB + GB - 1);
                  o[(g*GB + GB - 1)*8 +: 8] = byt(a, g*GB);
               end
         3'd5: begin
                  o = '0;
                  for (int j = 0; j < RB / 2; j++)
                     o[j*8 +: 8] = ($signed(byt(a, 2*j)) >= $signed(byt(a, 2*j+1)))
                                   ? byt(a, 2*j) : byt(a, 2*j+1);
               end
         default: ;
      endcase
      return o;
   endfunction

   // driver: one operation per falling edge, expected outcome queued
   task automatic issue(input logic vld, input logic [2:0] op, input logic [2:0] sa,
                        input logic [2:0] sb, input logic [1:0] d, input logic [5:0] imm,
                        input string tag);
      exp_t e;
      logic [W-1:0] a;
      @(negedge clk);
      op_valid = vld; op_code = op; op_src_a = sa; op_src_b = sb; op_dst = d; op_imm = imm;
      a = m_src(sa);
      e.v = vld && (op != 3'd6) && (op != 3'd7);
      e.d = d;
      e.row = m_model(op, a, m_src(sb), imm);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (e.v) m_regs[d] = e.row;
      if (vld && op == 3'd6) m_mask = a[RB-1:0];
   endtask

   // monitor: compare one entry just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (res_valid !== e.v || (e.v && (res_dst !== e.d || res_row !== e.row))) begin
               errors++;
               $display("FAIL %s: valid=%0b dst=%0d row=%h expected valid=%0b dst=%0d row=%h",
                        t, res_valid, res_dst, res_row, e.v, e.d, e.row);
            end
         end
      end
   end

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < RB; i++) begin
         mem_row_a[i*8 +: 8] = 8'(i * 7 + 3);
         mem_row_b[i*8 +: 8] = 8'(i) ^ 8'hA5;
         fwd_row[i*8 +: 8]   = 8'(255 - i * 3);
      end
      for (int r = 0; r < 4; r++) m_regs[r] = '0;
      m_mask = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_row !== '0) begin
         errors++;
         $display("FAIL R1: valid=%0b row=%h expected valid=0 row=0", res_valid, res_row);
      end
      rst_n = 1'b1;

      // R1: registers start at zero
      issue(1, 3'd0, 3'd5, 3'd0, 2'd1, 6'd0, "R1 reg3 zero after reset");
      // R2: copy each kind of source
      issue(1, 3'd0, 3'd0, 3'd0, 2'd0, 6'd0, "R2 copy mem A");
      issue(1, 3'd0, 3'd1, 3'd0, 2'd1, 6'd0, "R2 copy mem B");
      issue(1, 3'd0, 3'd6, 3'd0, 2'd2, 6'd0, "R2 copy forward");
      issue(1, 3'd0, 3'd7, 3'd0, 2'd3, 6'd0, "R2 copy zero");
      issue(1, 3'd0, 3'd4, 3'd0, 2'd3, 6'd0, "R2 copy reg2");
      // R3: all rotate codes
      for (int c = 0; c < 8; c++) issue(1, 3'd1, 3'd2, 3'd0, 2'd3, 6'(c), "R3 rotate");
      // R4: broadcast at two indices including the last
      issue(1, 3'd2, 3'd1, 3'd0, 2'd3, 6'd5, "R4 broadcast idx 5");
      issue(1, 3'd2, 3'd6, 3'd0, 2'd3, 6'd63, "R4 broadcast idx 63");
      // R5 with zero mask, then R8 load, then R5 with loaded mask
      issue(1, 3'd3, 3'd2, 3'd3, 2'd3, 6'd0, "R5 merge zero mask");
      issue(1, 3'd6, 3'd0, 3'd0, 2'd2, 6'd0, "R8 mask load silent");
      issue(1, 3'd3, 3'd2, 3'd3, 2'd3, 6'd0, "R5 merge loaded mask");
      issue(1, 3'd0, 3'd4, 3'd0, 2'd1, 6'd0, "R8 reg2 untouched by mask load");
      // R6 / R7
      issue(1, 3'd4, 3'd6, 3'd0, 2'd3, 6'd0, "R6 edge swap");
      issue(1, 3'd5, 3'd0, 3'd0, 2'd3, 6'd0, "R7 compress mem A");
      issue(1, 3'd5, 3'd6, 3'd0, 2'd3, 6'd0, "R7 compress forward");
      // R9: back-to-back dependent rotates on reg0
      issue(1, 3'd1, 3'd2, 3'd0, 2'd0, 6'd7, "R9 chain step 1");
      issue(1, 3'd1, 3'd2, 3'd0, 2'd0, 6'd6, "R9 chain step 2");
      issue(1, 3'd0, 3'd2, 3'd0, 2'd2, 6'd0, "R9 chain readback");
      // R10: code 7 leaves reg1 alone
      issue(1, 3'd7, 3'd7, 3'd0, 2'd1, 6'd0, "R10 nop silent");
      issue(1, 3'd0, 3'd3, 3'd0, 2'd2, 6'd0, "R10 reg1 unchanged");
      // R11: idle cycle with a would-be zeroing copy and mask load
      issue(0, 3'd0, 3'd7, 3'd0, 2'd0, 6'd0, "R11 idle copy");
      issue(0, 3'd6, 3'd7, 3'd0, 2'd0, 6'd0, "R11 idle mask load");
      issue(1, 3'd0, 3'd2, 3'd0, 2'd3, 6'd0, "R11 reg0 unchanged");
      issue(1, 3'd3, 3'd6, 3'd7, 2'd3, 6'd0, "R11 mask unchanged");

      @(negedge clk);
      op_valid = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9: %0d results outstanding, expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule